// File: doc/BRIEF.md
# Up/Down Loadable Counter Bank with Cascade and Restricted-Range Variants

The block holds three counters built from one 4-bit cell. Each cell counts up or down and takes a synchronous parallel load. An active-low enable gates all of its actions, and an active-high clear takes effect at once, with no clock edge. An active-low carry flags the terminal count.

The first counter chains two cells into an 8-bit up/down counter. The low nibble's carry lets the high nibble step for one clock only. The other two counters are single cells that always count up, and each feeds a condition back into its own load input:
- The first reloads 0110 from its carry, so it runs 1111 -> 0110 and not 1111 -> 0000.
- The second reloads 0000 when it detects 1100, so it cycles 0..12.

The three counters share the clock, the clear and the enable. Only the cascade takes the load inputs and the direction input.

Top module: `updn_counter_bank`

## Requirements
- R1: With en_ni=0, ld_ni=1 and up_i=1, q_o increments by one on each rising clock, wrapping 0xFF -> 0x00.
- R2: With en_ni=0, ld_ni=1 and up_i=0, q_o decrements by one on each rising clock, wrapping 0x00 -> 0xFF.
- R3: clr_i=1 forces q_o, wrap_q_o and lim_q_o to zero immediately, with no clock edge.
- R4: With en_ni=0 and ld_ni=0, the next rising clock loads d_i into q_o, replacing the count step.
- R5: With en_ni=1, all three counters keep their values, even if ld_ni=0 and d_i differs.
- R6: While clr_i=1, the counters stay at zero through clock edges, whatever the enable and load inputs are.
- R7: co_no is 0 exactly when q_o is at the terminal count for the current direction: 0xFF when up_i=1, 0x00 when up_i=0. Otherwise co_no is 1.
- R8: wrap_q_o counts up when enabled and goes 1111 -> 0110. wrap_co_no is 0 exactly when wrap_q_o=1111.
- R9: lim_q_o counts up when enabled through 0..12 (0000..1100), then returns to 0000.
- R10: The two restricted counters ignore up_i, ld_ni and d_i.
- R11: rst_ni=0 asynchronously clears all three counters to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous chip reset, active low |
| clr_i | input | 1 | Asynchronous clear of all counters, active high |
| up_i | input | 1 | Cascade direction: 1 up, 0 down |
| ld_ni | input | 1 | Cascade synchronous load, active low |
| en_ni | input | 1 | Shared enable, active low |
| d_i | input | 8 | Cascade load value |
| q_o | output | 8 | Cascade count |
| co_no | output | 1 | Cascade terminal-count flag, active low |
| wrap_q_o | output | 4 | Count of the counter that wraps to 0110 |
| wrap_co_no | output | 1 | Carry of the wrap-to-0110 counter, active low |
| lim_q_o | output | 4 | Count of the 0..12 counter |

## Verification
The hardest case to reach is the clear arriving between clock edges. It has to appear on all three counters before any edge, and it has to win over a load and enable that are active at the same time.

The stimulus raises clr_i a quarter period after a falling edge. It samples the outputs one time unit later, then holds the clear across a rising edge with load and enable both asserted.

The high-nibble carry transitions are reached by running the cascade more than a full 256-step lap in each direction. The same run also takes both restricted counters through many reload cycles.

// File: rtl/updn_counter_pkg.sv
package updn_counter_pkg;
  typedef enum logic {
    RELOAD_ON_CARRY = 1'b0,
    RELOAD_ON_LIMIT = 1'b1
  } reload_mode_e;
endpackage

// File: rtl/updn_nibble.sv
module updn_nibble #(
  parameter int unsigned W         = 4,
  parameter bit          DIR_CARRY = 1'b0  // 1: terminal follows direction
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         up_i,
  input  logic         ld_ni,
  input  logic         en_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic         co_no
);
  logic [W-1:0] q_q;
  logic [W-1:0] term;

  always_ff @(posedge clk_i or negedge rst_ni or posedge clr_i) begin
    if (!rst_ni)      q_q <= '0;
    else if (clr_i)   q_q <= '0;
    else if (!en_ni) begin
      if (!ld_ni)     q_q <= d_i;
      else if (up_i)  q_q <= q_q + W'(1);
      else            q_q <= q_q - W'(1);
    end
  end

  generate
    if (DIR_CARRY) begin : g_dir_term
      assign term = up_i ? '1 : '0;
    end else begin : g_fixed_term
      assign term = '1;
    end
  endgenerate

  assign q_o   = q_q;
  assign co_no = ~(q_q == term);
endmodule

// File: rtl/updn_cascade.sv
module updn_cascade #(
  parameter int unsigned NW     = 4,
  parameter int unsigned STAGES = 2,
  localparam int unsigned CW    = NW * STAGES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          up_i,
  input  logic          ld_ni,
  input  logic          en_ni,
  input  logic [CW-1:0] d_i,
  output logic [CW-1:0] q_o,
  output logic          co_no
);
  // chain_n[i] low: every stage below i sits at its terminal count
  logic [STAGES:0]   chain_n;
  logic [STAGES-1:0] stage_co_n;

  assign chain_n[0] = 1'b0;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic stage_en_n;
    // a load reaches every stage; counting ripples through the carry chain
    assign stage_en_n     = en_ni | (ld_ni & chain_n[s]);
    assign chain_n[s+1]   = chain_n[s] | stage_co_n[s];

    updn_nibble #(.W(NW), .DIR_CARRY(1'b1)) u_nib (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (clr_i),
      .up_i  (up_i),
      .ld_ni (ld_ni),
      .en_ni (stage_en_n),
      .d_i   (d_i[s*NW +: NW]),
      .q_o   (q_o[s*NW +: NW]),
      .co_no (stage_co_n[s])
    );
  end

  assign co_no = chain_n[STAGES];
endmodule

// File: rtl/updn_restricted.sv
module updn_restricted
  import updn_counter_pkg::*;
#(
  parameter int unsigned  NW       = 4,
  parameter reload_mode_e MODE     = RELOAD_ON_CARRY,
  parameter logic [NW-1:0] LOAD_VAL = '0,
  parameter logic [NW-1:0] LIMIT    = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_ni,
  output logic [NW-1:0] q_o,
  output logic          co_no
);
  logic [NW-1:0] q;
  logic          co_n;
  logic          ld_n;

  generate
    if (MODE == RELOAD_ON_CARRY) begin : g_carry_reload
      assign ld_n = co_n;
    end else begin : g_limit_reload
      assign ld_n = ~(q == LIMIT);
    end
  endgenerate

  updn_nibble #(.W(NW), .DIR_CARRY(1'b0)) u_nib (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_i),
    .up_i  (1'b1),
    .ld_ni (ld_n),
    .en_ni (en_ni),
    .d_i   (LOAD_VAL),
    .q_o   (q),
    .co_no (co_n)
  );

  assign q_o   = q;
  assign co_no = co_n;
endmodule

// File: rtl/updn_counter_bank.sv
module updn_counter_bank
  import updn_counter_pkg::*;
#(
  parameter int unsigned   NW        = 4,
  parameter int unsigned   STAGES    = 2,
  parameter logic [NW-1:0] WRAP_BASE = 4'b0110,
  parameter logic [NW-1:0] LIMIT     = 4'b1100,
  localparam int unsigned  CW        = NW * STAGES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          up_i,
  input  logic          ld_ni,
  input  logic          en_ni,
  input  logic [CW-1:0] d_i,
  output logic [CW-1:0] q_o,
  output logic          co_no,
  output logic [NW-1:0] wrap_q_o,
  output logic          wrap_co_no,
  output logic [NW-1:0] lim_q_o
);
  logic lim_co_unused;

  updn_cascade #(.NW(NW), .STAGES(STAGES)) u_cascade (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_i),
    .up_i  (up_i),
    .ld_ni (ld_ni),
    .en_ni (en_ni),
    .d_i   (d_i),
    .q_o   (q_o),
    .co_no (co_no)
  );

  updn_restricted #(
    .NW(NW), .MODE(RELOAD_ON_CARRY), .LOAD_VAL(WRAP_BASE), .LIMIT('1)
  ) u_wrap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_i),
    .en_ni (en_ni),
    .q_o   (wrap_q_o),
    .co_no (wrap_co_no)
  );

  updn_restricted #(
    .NW(NW), .MODE(RELOAD_ON_LIMIT), .LOAD_VAL('0), .LIMIT(LIMIT)
  ) u_lim (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_i),
    .en_ni (en_ni),
    .q_o   (lim_q_o),
    .co_no (lim_co_unused)
  );
endmodule

// File: rtl/updn_bank_checker.sv
module updn_bank_checker #(
  parameter int unsigned   NW        = 4,
  parameter int unsigned   CW        = 8,
  parameter logic [NW-1:0] WRAP_BASE = 4'b0110,
  parameter logic [NW-1:0] LIMIT     = 4'b1100
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          clr_i,
  input logic          up_i,
  input logic          ld_ni,
  input logic          en_ni,
  input logic [CW-1:0] d_i,
  input logic [CW-1:0] q_o,
  input logic          co_no,
  input logic [NW-1:0] wrap_q_o,
  input logic          wrap_co_no,
  input logic [NW-1:0] lim_q_o
);
  assert_up_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !en_ni && ld_ni && up_i) |=> (clr_i || q_o == CW'($past(q_o) + CW'(1))));

  assert_down_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !en_ni && ld_ni && !up_i) |=> (clr_i || q_o == CW'($past(q_o) - CW'(1))));

  assert_clear_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> (q_o == '0 && wrap_q_o == '0 && lim_q_o == '0));

  assert_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !en_ni && !ld_ni) |=> (clr_i || q_o == $past(d_i)));

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && en_ni) |=> (clr_i || ($stable(q_o) && $stable(wrap_q_o) && $stable(lim_q_o))));

  assert_wrap_reload_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !en_ni && !wrap_co_no) |=> (clr_i || wrap_q_o == WRAP_BASE));

  assert_lim_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lim_q_o <= LIMIT);
endmodule

bind updn_counter_bank updn_bank_checker #(
  .NW(NW), .CW(CW), .WRAP_BASE(WRAP_BASE), .LIMIT(LIMIT)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clr_i     (clr_i),
  .up_i      (up_i),
  .ld_ni     (ld_ni),
  .en_ni     (en_ni),
  .d_i       (d_i),
  .q_o       (q_o),
  .co_no     (co_no),
  .wrap_q_o  (wrap_q_o),
  .wrap_co_no(wrap_co_no),
  .lim_q_o   (lim_q_o)
);

// File: tb/updn_counter_bank_test.sv
module updn_counter_bank_test;
  localparam int CLK_P = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni, clr_i, up_i, ld_ni, en_ni;
  logic [7:0] d_i;
  logic [7:0] q_o;
  logic       co_no, wrap_co_no;
  logic [3:0] wrap_q_o, lim_q_o;

  int vectors = 0;
  int misses  = 0;
  int cyc     = 0;
  int m8 = 0, mw = 0, ml = 0;

  updn_counter_bank uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .up_i(up_i),
    .ld_ni(ld_ni), .en_ni(en_ni), .d_i(d_i), .q_o(q_o), .co_no(co_no),
    .wrap_q_o(wrap_q_o), .wrap_co_no(wrap_co_no), .lim_q_o(lim_q_o)
  );

  always #(CLK_P/2) clk_i = ~clk_i;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == 100000) begin
      misses++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, int'(q_o), m8);
    chk("R7 cascade carry", int'(co_no),
        (m8 == (up_i ? 255 : 0)) ? 0 : 1);
    chk("R8/R10 wrap count", int'(wrap_q_o), mw);
    chk("R8 wrap carry", int'(wrap_co_no), (mw == 15) ? 0 : 1);
    chk("R9/R10 limit count", int'(lim_q_o), ml);
  endtask

  task automatic step(input logic up, input logic ld_n, input logic en_n,
                      input logic [7:0] d, input string tag);
    up_i = up; ld_ni = ld_n; en_ni = en_n; d_i = d;
    if (!en_n) begin
      if (!ld_n)   m8 = int'(d);
      else if (up) m8 = (m8 + 1) % 256;
      else         m8 = (m8 + 255) % 256;
      mw = (mw == 15) ? 6 : mw + 1;
      ml = (ml == 12) ? 0 : ml + 1;
    end
    @(posedge clk_i);
    @(negedge clk_i);
    compare_all(tag);
  endtask

  initial begin
    rst_ni = 1'b0; clr_i = 1'b0; up_i = 1'b1; ld_ni = 1'b1; en_ni = 1'b1; d_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    compare_all("R11 reset state");

    // R1 full lap up plus wrap; R8, R9 restricted sequences ride along
    for (int i = 0; i < 262; i++) step(1'b1, 1'b1, 1'b0, 8'h00, "R1 count up");
    // R5 disabled, load requested and direction flipped: nothing moves
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b1, 8'hC3, "R5 hold");
    // R2 full lap down across 0x00
    for (int i = 0; i < 262; i++) step(1'b0, 1'b1, 1'b0, 8'h00, "R2 count down");
    // R4 loads; R10 wrappers keep counting up regardless of ld/d/up
    step(1'b0, 1'b0, 1'b0, 8'h0F, "R4 load 0F");
    step(1'b1, 1'b1, 1'b0, 8'h00, "R1 carry into high nibble");
    step(1'b1, 1'b0, 1'b0, 8'hFE, "R4 load FE");
    step(1'b1, 1'b1, 1'b0, 8'h00, "R1 to FF");
    step(1'b1, 1'b1, 1'b0, 8'h00, "R1 wrap to 00");
    step(1'b0, 1'b0, 1'b0, 8'h10, "R4 load 10");
    step(1'b0, 1'b1, 1'b0, 8'h00, "R2 borrow from high nibble");
    step(1'b1, 1'b0, 1'b0, 8'hA5, "R4 load A5");
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b0, 8'h00, "R1 count up");

    // R3 asynchronous clear mid-cycle
    #(CLK_P/4);
    clr_i = 1'b1;
    #1;
    m8 = 0; mw = 0; ml = 0;
    chk("R3 async clear q", int'(q_o), 0);
    chk("R3 async clear wrap", int'(wrap_q_o), 0);
    chk("R3 async clear limit", int'(lim_q_o), 0);
    // R6 clear holds over an edge with load and enable active
    up_i = 1'b1; ld_ni = 1'b0; en_ni = 1'b0; d_i = 8'h5A;
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R6 clear priority q", int'(q_o), 0);
    chk("R6 clear priority wrap", int'(wrap_q_o), 0);
    chk("R6 clear priority limit", int'(lim_q_o), 0);
    clr_i = 1'b0; ld_ni = 1'b1;
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 1'b0, 8'h00, "R1 after clear");

    // R11 reset mid-run
    #(CLK_P/4);
    rst_ni = 1'b0;
    #1;
    m8 = 0; mw = 0; ml = 0;
    compare_all("R11 async reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, 8'h00, "R1 after reset");

    summary();
    $finish;
  end
endmodule